// File: doc/BRIEF.md
# Programmable-Flag FIFO Channel

A single first-in first-out channel that moves 12-bit words from a write clock domain to a read clock domain. The two clocks may be fully independent or driven from one source. Words are written on rising edges of the write clock. The word at the head of the queue is registered onto the output on the rising edge of the read clock that accepts a read. An active-low output enable either passes the registered word to the output or drives all zeros.

Two threshold registers are loaded through the same data input. When the load strobe is low, the input word goes into the almost-empty threshold or the almost-full threshold instead of into the queue, and a select pin chooses which one. The channel reports empty, full, almost-empty and almost-full. Each side owns its pointer and its active-low asynchronous reset. Pointers cross between the domains as Gray code through two-flop synchronizers.

A two-bit mode input enables the queue only in its first-in first-out code. Every change of mode stalls reads for a fixed number of read-clock cycles while the pipeline flushes. Asserting the read reset ends that stall early.

Top module: `pff_fifo_channel`

## Requirements
- R1: Words are delivered in the order they were accepted, bit for bit. The registered output changes on the read-clock edge that accepts a read and holds its value otherwise.
- R2: A write is accepted on a write-clock edge when wr_en=1, load_n=1, mode=2'b00 and the channel is not full.
- R3: full is 1 exactly when DEPTH (default 16) words are stored. A write while full is ignored and the stored contents are unchanged.
- R4: empty is 1 exactly when no word is stored. A read while empty is ignored and the output keeps its value.
- R5: With load_n=0, din is written into a threshold register on the write-clock edge: thr_sel=0 selects almost-empty and thr_sel=1 selects almost-full. din[0] is the threshold LSB and din[11] its MSB. No word enters the queue, even when wr_en=1.
- R6: Once the pointers have settled, almost_empty is 1 exactly when the stored word count is at or below the almost-empty threshold (12-bit unsigned compare).
- R7: Once the pointers have settled, almost_full is 1 exactly when the free space (DEPTH minus count) is at or below the almost-full threshold.
- R8: With oe_n=1, dout is all zeros. With oe_n=0, dout shows the registered word. oe_n does not affect which reads are accepted.
- R9: wr_rst_n=0 clears the write pointer and restores both thresholds to their defaults (2 and 2). rd_rst_n=0 clears the read pointer, the output register and any flush stall. Asserting both together empties the channel.
- R10: With mode other than 2'b00, writes and reads are ignored.
- R11: After any change of mode seen on a read-clock edge, reads are ignored for FLUSH_CYC (default 8) further read-clock cycles, unless rd_rst_n is asserted, which ends the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Active-low asynchronous write-pointer and threshold reset |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Active-low asynchronous read-pointer and output reset |
| mode | input | 2 | Operating mode; 2'b00 enables the queue |
| wr_en | input | 1 | Write request |
| load_n | input | 1 | Active-low threshold load strobe |
| thr_sel | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| din | input | 12 | Data or threshold word |
| rd_en | input | 1 | Read request |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 12 | Registered read data, zero when disabled |
| full | output | 1 | Channel full (write domain) |
| almost_full | output | 1 | Free space at or below threshold (write domain) |
| empty | output | 1 | Channel empty (read domain) |
| almost_empty | output | 1 | Count at or below threshold (read domain) |

## Verification
Some properties are checked on every cycle. The stored count never exceeds the depth. A pointer never moves while its side reports full or empty, during a threshold load, in a non-queue mode, or during a flush stall. Each Gray pointer changes at most one bit per edge. Data ordering, the exact flag thresholds after synchronization, the threshold bit mapping, output-enable gating, the flush stall ending and the replay after a read-only reset are shown only by the bench's directed and random scenarios, which compare against a pointer-level model.

// File: rtl/pff_pkg.sv
package pff_pkg;

  localparam int PFF_GW = 16;

  typedef enum logic [1:0] {
    PFF_MODE_FIFO = 2'b00,
    PFF_MODE_ALT1 = 2'b01,
    PFF_MODE_ALT2 = 2'b10,
    PFF_MODE_ALT3 = 2'b11
  } pff_mode_e;

  typedef enum logic {
    PFF_THR_EMPTY = 1'b0,
    PFF_THR_FULL  = 1'b1
  } pff_thr_e;

  function automatic logic [PFF_GW-1:0] pff_bin2gray(input logic [PFF_GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PFF_GW-1:0] pff_gray2bin(input logic [PFF_GW-1:0] g);
    logic [PFF_GW-1:0] b;
    b[PFF_GW-1] = g[PFF_GW-1];
    for (int i = PFF_GW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side
  import pff_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              load_n,
  input  logic              thr_sel,
  input  logic              mode_ok,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W:0]   rd_gray_s,
  output logic [ADDR_W:0]   wr_gray,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              mem_we,
  output logic              full,
  output logic              almost_full,
  output logic [DATA_W-1:0] ae_thr,
  output logic [DATA_W-1:0] af_thr
);

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, level, free_cnt;
  logic          wr_accept, thr_load;

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  assign rbin_s      = PW'(pff_gray2bin(PFF_GW'(rd_gray_s)));
  assign level       = occupancy(wbin, rbin_s);
  assign full        = (level == PW'(DEPTH));
  assign free_cnt    = PW'(DEPTH) - level;
  assign almost_full = (DATA_W'(free_cnt) <= af_thr);
  assign thr_load    = !load_n;
  assign wr_accept   = wr_en && load_n && mode_ok && !full;
  assign mem_we      = wr_accept;
  assign wr_addr     = wbin[ADDR_W-1:0];
  assign wbin_nxt    = wbin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wr_gray <= '0;
    end else if (wr_accept) begin
      wbin    <= wbin_nxt;
      wr_gray <= PW'(pff_bin2gray(PFF_GW'(wbin_nxt)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_thr <= DATA_W'(AE_DEF);
      af_thr <= DATA_W'(AF_DEF);
    end else if (thr_load) begin
      if (pff_thr_e'(thr_sel) == PFF_THR_FULL) af_thr <= din;
      else                                      ae_thr <= din;
    end
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(wbin));

  assert_load_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |=> $stable(wbin));

  assert_mode_hold_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |=> $stable(wbin));

  assert_wr_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side
  import pff_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 12,
  parameter int FLUSH_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        mode_in,
  input  logic [ADDR_W:0]   wr_gray_s,
  input  logic [DATA_W-1:0] ae_thr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W:0]   rd_gray,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dout_q,
  output logic              empty,
  output logic              almost_empty
);

  localparam int PW = ADDR_W + 1;
  localparam int HW = $clog2(FLUSH_CYC + 1);

  pff_mode_e     mode_cur, mode_q;
  logic [HW-1:0] hold_cnt;
  logic [PW-1:0] rbin, rbin_nxt, wbin_s, level;
  logic          mode_chg, hold_busy, rd_accept;

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  assign mode_cur     = pff_mode_e'(mode_in);
  assign mode_chg     = (mode_cur != mode_q);
  assign hold_busy    = (hold_cnt != '0);
  assign wbin_s       = PW'(pff_gray2bin(PFF_GW'(wr_gray_s)));
  assign level        = occupancy(wbin_s, rbin);
  assign empty        = (level == '0);
  assign almost_empty = (DATA_W'(level) <= ae_thr);
  assign rd_accept    = rd_en && !empty && (mode_cur == PFF_MODE_FIFO) && !hold_busy && !mode_chg;
  assign rd_addr      = rbin[ADDR_W-1:0];
  assign rbin_nxt     = rbin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PFF_MODE_FIFO;
      hold_cnt <= '0;
    end else begin
      mode_q <= mode_cur;
      if (mode_chg)       hold_cnt <= HW'(FLUSH_CYC);
      else if (hold_busy) hold_cnt <= hold_cnt - HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rd_gray <= '0;
      dout_q  <= '0;
    end else if (rd_accept) begin
      rbin    <= rbin_nxt;
      rd_gray <= PW'(pff_bin2gray(PFF_GW'(rbin_nxt)));
      dout_q  <= rd_data;
    end
  end

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> ($stable(rbin) && $stable(dout_q)));

  assert_flush_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |=> $stable(rbin));

  assert_mode_hold_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur != PFF_MODE_FIFO) |=> $stable(rbin));

  assert_rd_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

// File: rtl/pff_fifo_channel.sv
module pff_fifo_channel
  import pff_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 12,
  parameter int AE_DEF    = 2,
  parameter int AF_DEF    = 2,
  parameter int FLUSH_CYC = 8
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic              load_n,
  input  logic              thr_sel,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              almost_full,
  output logic              empty,
  output logic              almost_empty
);

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] rd_data, dout_q, ae_thr, af_thr;
  logic              mem_we, mode_ok;

  assign mode_ok = (pff_mode_e'(mode) == PFF_MODE_FIFO);

  pff_wr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .load_n(load_n), .thr_sel(thr_sel),
    .mode_ok(mode_ok), .din(din), .rd_gray_s(rd_gray_s), .wr_gray(wr_gray),
    .wr_addr(wr_addr), .mem_we(mem_we), .full(full), .almost_full(almost_full),
    .ae_thr(ae_thr), .af_thr(af_thr)
  );

  pff_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  pff_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  pff_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(wr_addr), .wdata(din),
    .raddr(rd_addr), .rdata(rd_data)
  );

  pff_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLUSH_CYC(FLUSH_CYC)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .mode_in(mode),
    .wr_gray_s(wr_gray_s), .ae_thr(ae_thr), .rd_data(rd_data), .rd_gray(rd_gray),
    .rd_addr(rd_addr), .dout_q(dout_q), .empty(empty), .almost_empty(almost_empty)
  );

  assign dout = oe_n ? '0 : dout_q;

endmodule

// File: tb/tb_pff_fifo_channel.sv
module tb_pff_fifo_channel;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int FLUSH = 8;
  localparam int AE0   = 2;
  localparam int AF0   = 2;

  logic        clk, wr_rst_n, rd_rst_n, wr_en, load_n, thr_sel, rd_en, oe_n;
  logic [1:0]  mode;
  logic [11:0] din, dout;
  logic        full, almost_full, empty, almost_empty;

  int vecs = 0;
  int miss = 0;
  logic [11:0] mem_m [DEPTH];
  int wp, rp, ae_m, af_m, mode_m;
  logic [11:0] dout_m;

  pff_fifo_channel #(.ADDR_W(4), .DATA_W(12), .AE_DEF(AE0), .AF_DEF(AF0), .FLUSH_CYC(FLUSH)) dut (
    .wr_clk(clk), .wr_rst_n(wr_rst_n), .rd_clk(clk), .rd_rst_n(rd_rst_n), .mode(mode),
    .wr_en(wr_en), .load_n(load_n), .thr_sel(thr_sel), .din(din), .rd_en(rd_en),
    .oe_n(oe_n), .dout(dout), .full(full), .almost_full(almost_full), .empty(empty),
    .almost_empty(almost_empty)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int cnt_m();
    return (wp - rp) & 31;
  endfunction

  function automatic int exp_ae();
    return (cnt_m() <= ae_m) ? 1 : 0;
  endfunction

  function automatic int exp_af();
    return ((DEPTH - cnt_m()) <= af_m) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_state(input string ctx);
    check({ctx, " R4 empty"}, int'(empty), (cnt_m() == 0) ? 1 : 0);
    check({ctx, " R3 full"}, int'(full), (cnt_m() == DEPTH) ? 1 : 0);
    check({ctx, " R6 almost_empty"}, int'(almost_empty), exp_ae());
    check({ctx, " R7 almost_full"}, int'(almost_full), exp_af());
    check({ctx, " R1 dout"}, int'(dout), int'(dout_m));
  endtask

  task automatic wr_word(input logic [11:0] d);
    wr_en = 1'b1; din = d;
    cyc();
    wr_en = 1'b0;
    if (mode_m == 0 && cnt_m() < DEPTH) begin
      mem_m[wp & 15] = d;
      wp = (wp + 1) & 31;
    end
  endtask

  task automatic rd_word(input bit allowed);
    rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
    if (allowed && mode_m == 0 && cnt_m() > 0) begin
      dout_m = mem_m[rp & 15];
      rp = (rp + 1) & 31;
    end
  endtask

  task automatic both(input logic [11:0] d);
    int c;
    wr_en = 1'b1; rd_en = 1'b1; din = d;
    cyc();
    wr_en = 1'b0; rd_en = 1'b0;
    c = cnt_m();
    if (c > 0) begin
      dout_m = mem_m[rp & 15];
      rp = (rp + 1) & 31;
    end
    if (c < DEPTH) begin
      mem_m[wp & 15] = d;
      wp = (wp + 1) & 31;
    end
  endtask

  task automatic load_thr(input bit sel, input logic [11:0] val);
    load_n = 1'b0; thr_sel = sel; din = val; wr_en = 1'b1;
    cyc();
    load_n = 1'b1; wr_en = 1'b0;
    if (sel) af_m = int'(val);
    else     ae_m = int'(val);
  endtask

  task automatic joint_reset();
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    cyc();
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    wp = 0; rp = 0; dout_m = '0; ae_m = AE0; af_m = AF0;
  endtask

  initial begin
    cyc(150000);
    miss++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; load_n = 1'b1; thr_sel = 1'b0;
    oe_n = 1'b0; mode = 2'b00; din = '0;
    wp = 0; rp = 0; ae_m = AE0; af_m = AF0; mode_m = 0; dout_m = '0;
    cyc(2);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    cyc(2);
    check_state("R9 after reset");

    // R5: threshold loads through din, no word pushed although wr_en=1
    load_thr(1'b0, 12'd3);
    load_thr(1'b1, 12'd4);
    cyc(3);
    check("R5 load pushes nothing", int'(empty), 1);
    check_state("R5 thresholds");

    // R2 R3 R6 R7: fill to depth with flag checks each step
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(12'h0A5 ^ 12'(i * 273));
      cyc(3);
      check_state("R2 fill");
    end
    wr_word(12'hFFF);
    cyc(3);
    check_state("R3 write when full");

    // R5: MSB and LSB mapping of the threshold word
    load_thr(1'b0, 12'h800);
    cyc(1);
    check("R5 ae MSB", int'(almost_empty), 1);
    load_thr(1'b1, 12'h001);
    cyc(1);
    check("R5 af LSB", int'(almost_full), 1);
    load_thr(1'b0, 12'd3);
    load_thr(1'b1, 12'd4);
    cyc(3);
    check_state("R5 restore");

    // R8: read while output disabled, then enable
    oe_n = 1'b1;
    rd_word(1'b1);
    #1;
    check("R8 disabled dout zero", int'(dout), 0);
    oe_n = 1'b0;
    #1;
    check("R8 enabled dout", int'(dout), int'(dout_m));
    cyc(3);

    // R1: drain in order
    while (cnt_m() > 0) begin
      rd_word(1'b1);
      cyc(3);
      check_state("R1 drain");
    end
    rd_word(1'b1);
    cyc(3);
    check_state("R4 read when empty");

    // R10: non-queue mode ignores reads and writes
    wr_word(12'h5A3);
    cyc(3);
    mode = 2'b01; mode_m = 1;
    cyc();
    rd_word(1'b0);
    wr_word(12'h3C3);
    cyc(3);
    check_state("R10 alt mode");

    // R11: stall after returning to queue mode
    mode = 2'b00; mode_m = 0;
    cyc();
    cyc(2);
    rd_word(1'b0);
    cyc(1);
    check("R11 stalled read", int'(dout), int'(dout_m));
    cyc(FLUSH + 2);
    rd_word(1'b1);
    cyc(3);
    check("R11 read after flush", int'(dout), 12'h5A3);
    check_state("R11 after flush");

    // R11 R9: joint reset ends stall, restores thresholds
    mode = 2'b10; mode_m = 1;
    cyc();
    mode = 2'b00; mode_m = 0;
    cyc();
    joint_reset();
    cyc(2);
    check_state("R9 joint reset");
    wr_word(12'h777);
    cyc(3);
    rd_word(1'b1);
    cyc(1);
    check("R11 reset clears stall", int'(dout), 12'h777);
    cyc(2);
    check_state("R9 defaults");

    // R9: read-only reset replays from slot zero
    wr_word(12'h101);
    wr_word(12'h202);
    wr_word(12'h303);
    cyc(3);
    rd_word(1'b1);
    rd_word(1'b1);
    rd_rst_n = 1'b0;
    #1;
    check("R9 rd reset clears dout", int'(dout), 0);
    cyc();
    rd_rst_n = 1'b1;
    rp = 0; dout_m = '0;
    cyc(3);
    check_state("R9 rd reset");
    rd_word(1'b1);
    cyc(3);
    check("R9 replay slot zero", int'(dout), 12'h777);
    check_state("R9 replay");

    // Random phase
    joint_reset();
    cyc(2);
    load_thr(1'b0, 12'($urandom % 18));
    load_thr(1'b1, 12'($urandom % 18));
    cyc(3);
    for (int it = 0; it < 400; it++) begin
      int r;
      int wbias;
      r = int'($urandom % 10);
      wbias = (it % 100 < 50) ? 6 : 3;
      if (r < wbias)          wr_word(12'($urandom));
      else if (r < wbias + 3) rd_word(1'b1);
      else                    both(12'($urandom));
      cyc(3);
      check_state("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule